// File: doc/BRIEF.md
# Host-Attached Asynchronous Serial Adapter

This block connects an 8-bit microprocessor bus to an asynchronous serial line in the manner of a classic byte-wide serial adapter. The host reaches four registers through a 3-bit chip select, an access strobe, a register-select line and a read/not-write line, with separate byte-wide input and output data buses. A control register sets the clock ratio, the transmitter control field and the receive interrupt enable. A status register reports buffer, error, modem and interrupt state. A transmit data register feeds the serializer, and a receive data register holds the last assembled byte.

Frames are fixed at one start bit, eight data bits sent least significant bit first, and one stop bit. The transmit line advances on falling edges of a separate transmit clock. The receive line is sampled on rising edges of a separate receive clock, divided by 1, 16 or 64. Both serial clocks and all modem inputs are brought into the system clock domain through synchronizers. The modem lines cover request-to-send, which follows the transmitter control field, clear-to-send, which masks the transmit-empty flag, and carrier detect, whose loss latches a status flag and can raise an interrupt.

Top module: `serial_host_adapter`

## Requirements
- R1: The block responds only while `cs_i` equals 3'b110 and `en_i` is high. One access completes per rising edge of that selected condition. Writes made under any other select value change nothing, and `do_o` is 0 whenever no read is selected.
- R2: During a read, `rs_i`=0 returns status and `rs_i`=1 returns the received byte. During a write, `rs_i`=0 loads control and `rs_i`=1 loads the transmit byte.
- R3: `rts_no` is high only when control bits [6:5] equal 2'b10, and low for the other three values. It follows a control write on the next cycle.
- R4: Status bit 3 mirrors the synchronized `cts_ni` level. Status bit 1 (transmit empty) reads 0 whenever that level is high.
- R5: A written byte goes out on `tx_o` as a 0 start bit, then eight data bits LSB first, then a 1 stop bit. Each bit changes only after a falling `tx_clk_i` edge. The line idles at 1, and a byte written while a frame is shifting is sent right after it.
- R6: Control bits [1:0] set the bit length in serial clock periods for both directions: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 64.
- R7: A received frame sets status bit 0 and places its byte in the receive register. A received-byte read clears bit 0.
- R8: Status bit 4 is set when the stop bit of the last frame sampled as 0, and is cleared by the next frame whose stop bit is 1.
- R9: A frame that completes while bit 0 is still set raises status bit 5 and keeps the earlier byte. A received-byte read clears bit 5.
- R10: A rising edge on `dcd_ni` sets status bit 2. The bit clears only on a received-byte read that follows a status read made while the bit was set.
- R11: The interrupt is pending when control bit 7 is set and any of status bits 0, 5 or 2 is set, or when control [6:5]=2'b01 and status bit 1 is set. Status bit 7 and `irq_no` (active low) both show the pending state. Status bit 6 is always 0.
- R12: Writing 2'b11 to control [1:0] clears status bits 0, 2, 4 and 5, discards any pending transmit byte, and holds `tx_o` at 1 until another ratio is written.
- R13: A low `rst_ni` clears control, flags and buffers at once, without a clock. Status then reads 0x02 while `cts_ni` is low, `irq_no` is 1, `rts_no` is 0 and `tx_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 3 | Chip select, matches at 3'b110 |
| en_i | input | 1 | Bus access strobe, active high |
| rs_i | input | 1 | Register select |
| rnw_i | input | 1 | 1 = read, 0 = write |
| di_i | input | 8 | Write data from host |
| do_o | output | 8 | Read data to host |
| irq_no | output | 1 | Interrupt request, active low |
| tx_clk_i | input | 1 | Transmit bit clock |
| tx_o | output | 1 | Serial transmit line |
| rx_clk_i | input | 1 | Receive sampling clock |
| rx_i | input | 1 | Serial receive line |
| cts_ni | input | 1 | Clear-to-send, active low |
| dcd_ni | input | 1 | Carrier detect, active low |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
Register writes take effect on the first clock edge of the selected strobe. `rts_no` and `irq_no` settle one cycle later, and status reads are combinational, so the bench reads them a full cycle after each write. Modem inputs and both serial clocks pass through two synchronizer stages and an edge flop, so their effects appear about three system cycles late. The bench therefore waits several cycles after any modem change, and it changes serial inputs only on falling serial clock edges, half a serial period away from the sampling edge. The transmit monitor samples `tx_o` on rising `tx_clk_i` edges, eight system cycles after each shift. Received bytes are read only after the full stop bit has been driven.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int DW      = 8;
  localparam int MAX_DIV = 64;
  localparam int CNT_W   = $clog2(MAX_DIV);

  localparam logic [2:0] CS_MATCH = 3'b110;

  // status bit positions
  localparam int ST_RXF  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_DCD  = 2;
  localparam int ST_CTS  = 3;
  localparam int ST_FE   = 4;
  localparam int ST_OVR  = 5;
  localparam int ST_PE   = 6;
  localparam int ST_IRQ  = 7;

  typedef enum logic [1:0] {
    RATIO_1  = 2'b00,
    RATIO_16 = 2'b01,
    RATIO_64 = 2'b10,
    RATIO_MR = 2'b11
  } ratio_e;

  function automatic logic [CNT_W-1:0] ratio_last(input ratio_e r);
    case (r)
      RATIO_16: return CNT_W'(15);
      RATIO_64: return CNT_W'(MAX_DIV-1);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] ratio_half(input ratio_e r);
    case (r)
      RATIO_16: return CNT_W'(7);
      RATIO_64: return CNT_W'(MAX_DIV/2-1);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/sha_sync.sv
module sha_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sha_tx.sv
module sha_tx
  import sha_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] div_last_i,
  input  logic             load_i,
  input  logic [DW-1:0]    data_i,
  output logic             empty_o,
  output logic             tx_o
);
  localparam int FW   = DW + 2;
  localparam int BC_W = $clog2(FW);

  logic [DW-1:0]    tdr;
  logic             full, busy;
  logic [FW-1:0]    sh;
  logic [BC_W-1:0]  bit_cnt;
  logic [CNT_W-1:0] div_cnt;
  logic             bit_end, frame_end, start;

  assign bit_end   = busy & (div_cnt == div_last_i);
  assign frame_end = bit_end & (bit_cnt == BC_W'(FW-1));
  assign start     = tick_i & full & (~busy | frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr     <= '0;
      full    <= 1'b0;
      busy    <= 1'b0;
      sh      <= '1;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else if (hold_i) begin
      full    <= 1'b0;
      busy    <= 1'b0;
      sh      <= '1;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (start) begin
        sh      <= {1'b1, tdr, 1'b0};
        busy    <= 1'b1;
        bit_cnt <= '0;
        div_cnt <= '0;
        full    <= 1'b0;
      end else if (tick_i && busy) begin
        if (frame_end) begin
          busy    <= 1'b0;
          sh      <= '1;
          div_cnt <= '0;
        end else if (bit_end) begin
          sh      <= {1'b1, sh[FW-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
          div_cnt <= '0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
      // a byte written during a frame waits for the next start
      if (load_i) begin
        tdr  <= data_i;
        full <= 1'b1;
      end
    end
  end

  assign empty_o = ~full;
  assign tx_o    = sh[0];
endmodule

// File: rtl/sha_rx.sv
module sha_rx
  import sha_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] div_last_i,
  input  logic [CNT_W-1:0] half_last_i,
  input  logic             rd_data_i,
  output logic [DW-1:0]    data_o,
  output logic             full_o,
  output logic             ovr_o,
  output logic             fe_o
);
  localparam int BC_W = $clog2(DW + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [BC_W-1:0]  bit_cnt;
  logic [DW-1:0]    sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      cnt     <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      data_o  <= '0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      fe_o    <= 1'b0;
    end else if (hold_i) begin
      busy    <= 1'b0;
      cnt     <= '0;
      bit_cnt <= '0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      fe_o    <= 1'b0;
    end else begin
      if (rd_data_i) begin
        full_o <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (tick_i) begin
        if (!busy) begin
          // start bit must stay low up to its middle
          if (rx_i)                    cnt <= '0;
          else if (cnt == half_last_i) begin
            busy    <= 1'b1;
            cnt     <= '0;
            bit_cnt <= '0;
          end else                     cnt <= cnt + 1'b1;
        end else if (cnt == div_last_i) begin
          cnt <= '0;
          if (bit_cnt == BC_W'(DW)) begin
            busy <= 1'b0;
            fe_o <= ~rx_i;
            if (full_o && !rd_data_i) ovr_o <= 1'b1;
            else begin
              data_o <= sh;
              full_o <= 1'b1;
            end
          end else begin
            sh      <= {rx_i, sh[DW-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_host_adapter.sv
module serial_host_adapter
  import sha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cs_i,
  input  logic          en_i,
  input  logic          rs_i,
  input  logic          rnw_i,
  input  logic [DW-1:0] di_i,
  output logic [DW-1:0] do_o,
  output logic          irq_no,
  input  logic          tx_clk_i,
  output logic          tx_o,
  input  logic          rx_clk_i,
  input  logic          rx_i,
  input  logic          cts_ni,
  input  logic          dcd_ni,
  output logic          rts_no
);
  localparam int         NS     = 5;
  localparam logic [NS-1:0] NS_RST = 5'b00101;

  // host access decode
  logic sel, sel_q, strobe;
  logic wr_ctrl, wr_tdr, rd_stat, rd_data;

  assign sel     = (cs_i == CS_MATCH) & en_i;
  assign strobe  = sel & ~sel_q;
  assign wr_ctrl = strobe & ~rnw_i & ~rs_i;
  assign wr_tdr  = strobe & ~rnw_i &  rs_i;
  assign rd_stat = strobe &  rnw_i & ~rs_i;
  assign rd_data = strobe &  rnw_i &  rs_i;

  // control register, bits 4:2 have no function in this frame format
  ratio_e     ratio;
  logic [1:0] tx_ctl;
  logic       rx_ie;
  logic       hold;
  logic       ctrl_unused;

  assign ctrl_unused = ^di_i[4:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      ratio  <= RATIO_1;
      tx_ctl <= 2'b00;
      rx_ie  <= 1'b0;
    end else begin
      sel_q <= sel;
      if (wr_ctrl) begin
        ratio  <= ratio_e'(di_i[1:0]);
        tx_ctl <= di_i[6:5];
        rx_ie  <= di_i[7];
      end
    end
  end

  assign hold = (ratio == RATIO_MR);

  // line synchronizers and edge detect
  logic [NS-1:0] sync_q;
  logic txc_s, rxc_s, rx_s, cts_s, dcd_s;
  logic txc_q, rxc_q, dcd_q;
  logic tx_tick, rx_tick, dcd_rise;

  sha_sync #(.W(NS), .STAGES(SYNC_STAGES), .RST_VAL(NS_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tx_clk_i, rx_clk_i, rx_i, cts_ni, dcd_ni}),
    .q_o    (sync_q)
  );

  assign {txc_s, rxc_s, rx_s, cts_s, dcd_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q <= 1'b0;
      rxc_q <= 1'b0;
      dcd_q <= 1'b1;
    end else begin
      txc_q <= txc_s;
      rxc_q <= rxc_s;
      dcd_q <= dcd_s;
    end
  end

  assign tx_tick  = txc_q & ~txc_s;
  assign rx_tick  = ~rxc_q & rxc_s;
  assign dcd_rise = ~dcd_q & dcd_s;

  // datapaths
  logic          tx_empty;
  logic [DW-1:0] rx_data;
  logic          rx_full, rx_ovr, rx_fe;

  sha_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tx_tick),
    .hold_i     (hold),
    .div_last_i (ratio_last(ratio)),
    .load_i     (wr_tdr),
    .data_i     (di_i),
    .empty_o    (tx_empty),
    .tx_o       (tx_o)
  );

  sha_rx u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (rx_tick),
    .rx_i        (rx_s),
    .hold_i      (hold),
    .div_last_i  (ratio_last(ratio)),
    .half_last_i (ratio_half(ratio)),
    .rd_data_i   (rd_data),
    .data_o      (rx_data),
    .full_o      (rx_full),
    .ovr_o       (rx_ovr),
    .fe_o        (rx_fe)
  );

  // carrier-lost latch: cleared by status read then data read
  logic dcd_lost, dcd_armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcd_lost  <= 1'b0;
      dcd_armed <= 1'b0;
    end else if (hold) begin
      dcd_lost  <= 1'b0;
      dcd_armed <= 1'b0;
    end else if (dcd_rise) begin
      dcd_lost  <= 1'b1;
      dcd_armed <= 1'b0;
    end else if (rd_stat && dcd_lost) begin
      dcd_armed <= 1'b1;
    end else if (rd_data && dcd_armed) begin
      dcd_lost  <= 1'b0;
      dcd_armed <= 1'b0;
    end
  end

  // status and interrupt
  logic          tdre, irq_pend;
  logic [DW-1:0] status;

  assign tdre     = tx_empty & ~cts_s;
  assign irq_pend = (rx_ie & (rx_full | rx_ovr | dcd_lost))
                  | ((tx_ctl == 2'b01) & tdre);

  always_comb begin
    status         = '0;
    status[ST_RXF] = rx_full;
    status[ST_TXE] = tdre;
    status[ST_DCD] = dcd_lost;
    status[ST_CTS] = cts_s;
    status[ST_FE]  = rx_fe;
    status[ST_OVR] = rx_ovr;
    status[ST_PE]  = 1'b0;
    status[ST_IRQ] = irq_pend;
  end

  assign do_o   = (sel & rnw_i) ? (rs_i ? rx_data : status) : '0;
  assign irq_no = ~irq_pend;
  assign rts_no = (tx_ctl == 2'b10);
endmodule

// File: rtl/serial_host_adapter_chk.sv
module serial_host_adapter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cs_i,
  input logic       en_i,
  input logic       rs_i,
  input logic       rnw_i,
  input logic [7:0] di_i,
  input logic [7:0] do_o,
  input logic       irq_no,
  input logic       rts_no,
  input logic       tx_o,
  input logic       tx_tick_i,
  input logic       hold_i
);
  logic sel_c, sel_cq, ctrl_wr_c, stat_rd_c;

  assign sel_c     = (cs_i == 3'b110) && en_i;
  assign ctrl_wr_c = sel_c && !sel_cq && !rnw_i && !rs_i;
  assign stat_rd_c = sel_c && rnw_i && !rs_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_cq <= 1'b0;
    else         sel_cq <= sel_c;

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_c && rnw_i) |-> (do_o == 8'h00));

  // R3
  rts_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_c |=> (rts_no == ($past(di_i[6]) && !$past(di_i[5]))));

  // R4
  cts_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_c && do_o[1]) |-> !do_o[3]);

  // R11
  irq_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_c |-> (do_o[7] == !irq_no));

  // R11
  parity_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_c |-> !do_o[6]);

  // R9
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_c && do_o[5]) |-> do_o[0]);

  // R5
  tx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_o != $past(tx_o)) && !$past(hold_i)) |-> $past(tx_tick_i));

  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> tx_o);
endmodule

bind serial_host_adapter serial_host_adapter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .en_i      (en_i),
  .rs_i      (rs_i),
  .rnw_i     (rnw_i),
  .di_i      (di_i),
  .do_o      (do_o),
  .irq_no    (irq_no),
  .rts_no    (rts_no),
  .tx_o      (tx_o),
  .tx_tick_i (tx_tick),
  .hold_i    (hold)
);

// File: tb/serial_host_adapter_tb.sv
`timescale 1ns/1ps
module serial_host_adapter_tb;
  logic       clk, rst_ni;
  logic [2:0] cs;
  logic       en, rs, rnw;
  logic [7:0] di, do_w;
  logic       irq_no, tx_clk, tx_o, rx_clk, rx_i, cts_ni, dcd_ni, rts_no;

  int n_chk = 0, n_fail = 0, div_n = 1;
  bit done = 0;
  logic [7:0] tx_exp [$];

  serial_host_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .en_i(en), .rs_i(rs), .rnw_i(rnw),
    .di_i(di), .do_o(do_w), .irq_no(irq_no), .tx_clk_i(tx_clk), .tx_o(tx_o),
    .rx_clk_i(rx_clk), .rx_i(rx_i), .cts_ni(cts_ni), .dcd_ni(dcd_ni), .rts_no(rts_no)
  );

  initial begin clk = 0; forever #2.5 clk = ~clk; end
  initial begin tx_clk = 0; forever begin repeat (8) @(negedge clk); tx_clk = ~tx_clk; end end
  initial begin rx_clk = 0; repeat (3) @(negedge clk);
    forever begin repeat (8) @(negedge clk); rx_clk = ~rx_clk; end end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] c, input logic r, input logic [7:0] d);
    @(negedge clk); cs = c; en = 1; rnw = 0; rs = r; di = d;
    @(negedge clk); en = 0; cs = 3'b000;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    host_wr(3'b110, 1'b0, d);
    case (d[1:0]) 2'b01: div_n = 16; 2'b10: div_n = 64; default: div_n = 1; endcase
  endtask

  task automatic host_rd(input logic [2:0] c, input logic r, output logic [7:0] v);
    @(negedge clk); cs = c; en = 1; rnw = 1; rs = r;
    #1 v = do_w;
    @(negedge clk); en = 0; cs = 3'b000; rnw = 0;
  endtask

  task automatic rd_stat(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(3'b110, 1'b0, v); check(req, v, exp);
  endtask

  task automatic rd_data(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(3'b110, 1'b1, v); check(req, v, exp);
  endtask

  // driver: wait for empty buffer, load byte, push expectation
  task automatic tx_send(input logic [7:0] b);
    logic [7:0] s;
    do host_rd(3'b110, 1'b0, s); while (!s[1]);
    host_wr(3'b110, 1'b1, b);
    tx_exp.push_back(b);
  endtask

  task automatic tx_drain();
    wait (tx_exp.size() == 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stp);
    logic [9:0] f;
    f = {stp, b, 1'b0};
    @(negedge rx_clk);
    for (int j = 0; j < 10; j++) begin
      rx_i = f[j];
      repeat (div_n) @(negedge rx_clk);
    end
    rx_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  // monitor: decode frames at rising transmit clock, compare with queue
  initial begin
    logic [7:0] got, exp;
    logic stp;
    forever begin
      @(posedge tx_clk);
      if (rst_ni === 1'b1 && tx_o === 1'b0) begin
        for (int k = 0; k < 8; k++) begin
          repeat (div_n) @(posedge tx_clk);
          got[k] = tx_o;
        end
        repeat (div_n) @(posedge tx_clk);
        stp = tx_o;
        check("R5 stop bit", {7'b0, stp}, 8'h01);
        if (tx_exp.size() == 0) check("R5 R12 unexpected frame", got, 8'hxx);
        else begin
          exp = tx_exp.pop_front();
          check("R5 R6 frame byte", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int zeros;
    rst_ni = 0; cs = 0; en = 0; rs = 0; rnw = 0; di = 0;
    rx_i = 1; cts_ni = 0; dcd_ni = 0;
    repeat (5) @(negedge clk);
    check("R13 irq after reset", {7'b0, irq_no}, 8'h01);
    check("R13 rts after reset", {7'b0, rts_no}, 8'h00);
    check("R13 tx idle", {7'b0, tx_o}, 8'h01);
    rst_ni = 1;
    settle();
    rd_stat("R13 status after reset", 8'h02);

    // R1 deselected accesses
    host_wr(3'b111, 1'b0, 8'h40);
    check("R1 write ignored", {7'b0, rts_no}, 8'h00);
    host_rd(3'b100, 1'b0, v);
    check("R1 no read data", v, 8'h00);

    // R3 request-to-send map, R2 control write
    wr_ctrl(8'h40); check("R3 R2 rts 10", {7'b0, rts_no}, 8'h01);
    wr_ctrl(8'h60); check("R3 rts 11", {7'b0, rts_no}, 8'h00);
    wr_ctrl(8'h20); check("R3 rts 01", {7'b0, rts_no}, 8'h00);

    // R11 transmit-empty interrupt, R4 clear-to-send gating
    check("R11 tx irq", {7'b0, irq_no}, 8'h00);
    rd_stat("R11 status irq", 8'h82);
    cts_ni = 1; settle();
    check("R4 R11 irq masked", {7'b0, irq_no}, 8'h01);
    rd_stat("R4 cts high", 8'h08);
    cts_ni = 0; settle();
    wr_ctrl(8'h00);
    check("R3 rts 00", {7'b0, rts_no}, 8'h00);

    // R5 transmit, back to back, ratio 1
    tx_send(8'hA5); tx_send(8'h3C); tx_send(8'h01);
    tx_drain();
    // R6 ratios 16 and 64
    wr_ctrl(8'h01); tx_send(8'h81); tx_drain();
    wr_ctrl(8'h02); tx_send(8'h7E); tx_drain();

    // R7 receive, ratio 1 then 16
    wr_ctrl(8'h00);
    rx_send(8'h5A, 1);
    rd_stat("R7 rx full", 8'h03);
    rd_data("R7 R2 rx byte", 8'h5A);
    rd_stat("R7 cleared", 8'h02);
    wr_ctrl(8'h01);
    rx_send(8'hC3, 1);
    rd_stat("R6 R7 rx full 16", 8'h03);
    rd_data("R6 R7 rx byte 16", 8'hC3);

    // R8 framing error
    wr_ctrl(8'h00);
    rx_send(8'h11, 0);
    rd_stat("R8 framing set", 8'h13);
    rd_data("R8 byte kept", 8'h11);
    rx_send(8'h22, 1);
    rd_stat("R8 framing cleared", 8'h03);
    rd_data("R8 next byte", 8'h22);

    // R9 overrun
    rx_send(8'h01, 1); rx_send(8'h02, 1);
    rd_stat("R9 overrun", 8'h23);
    rd_data("R9 first kept", 8'h01);
    rd_stat("R9 cleared", 8'h02);

    // R11 receive interrupt
    wr_ctrl(8'h80);
    rx_send(8'h44, 1);
    check("R11 rx irq", {7'b0, irq_no}, 8'h00);
    rd_stat("R11 rx status", 8'h83);
    rd_data("R11 rx byte", 8'h44);
    check("R11 rx irq clear", {7'b0, irq_no}, 8'h01);

    // R10 carrier lost
    dcd_ni = 1; settle();
    check("R10 irq on carrier loss", {7'b0, irq_no}, 8'h00);
    rd_data("R10 data read first", 8'h44);
    rd_stat("R10 latch kept", 8'h86);
    rd_data("R10 data read second", 8'h44);
    rd_stat("R10 latch cleared", 8'h02);
    dcd_ni = 0; settle();
    rd_stat("R10 falling no effect", 8'h02);

    // R12 master reset
    wr_ctrl(8'h00);
    rx_send(8'h33, 1);
    wr_ctrl(8'h03);
    rd_stat("R12 flags cleared", 8'h02);
    host_wr(3'b110, 1'b1, 8'h55);
    zeros = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (tx_o !== 1'b1) zeros++; end
    check("R12 tx held", 8'(zeros), 8'h00);
    wr_ctrl(8'h00);
    repeat (400) @(negedge clk);
    check("R12 no pending send", 8'(tx_exp.size()), 8'h00);

    // R13 asynchronous reset
    wr_ctrl(8'h40);
    check("R3 rts before reset", {7'b0, rts_no}, 8'h01);
    #1 rst_ni = 0;
    #1 check("R13 async rts", {7'b0, rts_no}, 8'h00);
    @(negedge clk); rst_ni = 1;
    settle();
    rd_stat("R13 status after pulse", 8'h02);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule